// File: doc/BRIEF.md
# Bit Error Rate Flag Monitor

This block estimates how noisy a serial link is without any known test pattern. For every received bit it takes two samples from a bang-bang phase detector. One is taken at the centre of the eye. The other is taken at the crossing point between the previous bit and the current one. When two neighbouring centre samples agree but the crossing sample between them shows the opposite level, the block treats this as a false transition and counts it as an error.

Errors are counted over fixed windows of valid bits. A 2-bit select input picks one of four error-count thresholds. The flag rises as soon as the count inside a window reaches the selected threshold. Once raised, the flag stays high until a run of complete windows has each shown fewer errors than a quarter of that threshold. A debug output gives the count of the last completed window, and a one-cycle pulse marks each window boundary.

Top module: `ber_flag_monitor`

## Requirements
- R1: When `bit_valid` is high, an error is counted if `mid_sample` equals the previous bit's `mid_sample` and `edge_sample` differs from `mid_sample`. A change of `mid_sample` between the two bits never counts as an error.
- R2: The first valid bit after reset, and the first valid bit after any clock cycle with `bit_valid` low, is never counted as an error. Cycles with `bit_valid` low do not advance the window.
- R3: A window spans `WIN_BITS` valid bits. In the cycle after the last bit of a window, `win_done` is high for exactly one cycle and `win_count` shows that window's error count. `win_count` holds that value until the next boundary.
- R4: The in-window error count saturates at `TH3`, so `win_count` never exceeds `TH3`.
- R5: `rate_sel` codes 0, 1, 2 and 3 select the thresholds `TH0`, `TH1`, `TH2` and `TH3`. `ber_flag` goes high in the cycle after the valid bit that brings the window's count to the selected threshold.
- R6: A change on `rate_sel` takes effect only at the next window boundary. During reset, the value present on `rate_sel` is loaded directly.
- R7: Once set, `ber_flag` clears at the boundary that ends the `CLR_WINDOWS`-th consecutive complete window whose count is below the selected threshold divided by 4, rounded down. A window with a count at or above that level restarts the run.
- R8: A synchronous active-high `rst` clears `ber_flag`, `win_count`, `win_done` and all internal counters.
- R9: Outside reset, `ber_flag` falls only in a cycle where `win_done` is high. It never falls in the middle of a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe: this cycle carries one bit's sample pair |
| mid_sample | input | 1 | Sample taken at the centre of the eye |
| edge_sample | input | 1 | Sample taken at the crossing before this bit |
| rate_sel | input | 2 | Threshold select, codes 0 to 3 |
| ber_flag | output | 1 | Sticky high-error-rate flag |
| win_count | output | $clog2(TH3+1) | Error count of the last completed window |
| win_done | output | 1 | One-cycle pulse after each window boundary |

## Verification
The hardest situation to reach is the clear path: the flag must be set, and then several complete windows in a row must stay below a quarter of the threshold. The run must also be broken once by a window that sits exactly at the quarter level. The bench reaches this in few cycles by overriding the window length and the thresholds with small values. It drives one continuous stream whose mid-eye level is fixed at 0. Errors are injected by flipping only the crossing sample, and they are placed at the end of each window so that the bench always knows the exact count of every window.

// File: rtl/ber_flag_monitor.sv
module ber_flag_monitor #(
  parameter int WIN_BITS    = 65536,
  parameter int TH0         = 33,
  parameter int TH1         = 66,
  parameter int TH2         = 131,
  parameter int TH3         = 262,
  parameter int CLR_WINDOWS = 5,
  localparam int BW = $clog2(WIN_BITS),
  localparam int CW = $clog2(TH3 + 1),
  localparam int QW = $clog2(CLR_WINDOWS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_valid,
  input  logic          mid_sample,
  input  logic          edge_sample,
  input  logic [1:0]    rate_sel,
  output logic          ber_flag,
  output logic [CW-1:0] win_count,
  output logic          win_done
);

  logic [BW-1:0] bit_cnt;
  logic [CW-1:0] err_cnt;
  logic [QW-1:0] qual;
  logic [1:0]    sel_q;
  logic          prev_mid, prev_ok;
  logic [CW-1:0] th_set, th_clr;

  wire err_hit  = bit_valid && prev_ok && (mid_sample == prev_mid) && (edge_sample != mid_sample);
  wire last_bit = bit_valid && (bit_cnt == BW'(WIN_BITS - 1));
  wire [CW-1:0] cnt_next = (err_hit && (err_cnt < CW'(TH3))) ? err_cnt + 1'b1 : err_cnt;
  wire set_now   = cnt_next >= th_set;
  wire clean_win = cnt_next < th_clr;

  always_comb begin
    case (sel_q)
      2'd0:    th_set = CW'(TH0);
      2'd1:    th_set = CW'(TH1);
      2'd2:    th_set = CW'(TH2);
      default: th_set = CW'(TH3);
    endcase
    th_clr = th_set >> 2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      err_cnt   <= '0;
      qual      <= '0;
      sel_q     <= rate_sel;
      prev_mid  <= 1'b0;
      prev_ok   <= 1'b0;
      ber_flag  <= 1'b0;
      win_count <= '0;
      win_done  <= 1'b0;
    end else begin
      win_done <= last_bit;
      prev_ok  <= bit_valid;
      if (bit_valid) prev_mid <= mid_sample;
      if (bit_valid) begin
        if (last_bit) begin
          bit_cnt   <= '0;
          err_cnt   <= '0;
          win_count <= cnt_next;
          sel_q     <= rate_sel;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          err_cnt <= cnt_next;
        end
      end
      if (set_now) begin
        ber_flag <= 1'b1;
        qual     <= '0;
      end else if (last_bit) begin
        if (ber_flag && clean_win) begin
          if (qual == QW'(CLR_WINDOWS - 1)) begin
            ber_flag <= 1'b0;
            qual     <= '0;
          end else begin
            qual <= qual + 1'b1;
          end
        end else begin
          qual <= '0;
        end
      end
    end
  end

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!ber_flag && win_count == '0 && !win_done));

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    win_done |=> !win_done);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (err_cnt <= CW'(TH3)) && (win_count <= CW'(TH3)));

  a_r5_rise_on_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(ber_flag) |-> $past(bit_valid));

  a_r9_fall_at_boundary: assert property (@(posedge clk) disable iff (rst)
    ($fell(ber_flag) && !$past(rst)) |-> win_done);

  a_r7_qual_bound: assert property (@(posedge clk) disable iff (rst)
    qual < QW'(CLR_WINDOWS));

endmodule

// File: tb/ber_flag_monitor_tb.sv
module ber_flag_monitor_tb;
  localparam int WIN = 32;
  localparam int T0 = 4, T1 = 8, T2 = 12, T3 = 20;
  localparam int CLRW = 5;
  localparam int CW = $clog2(T3 + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic mid_s = 1'b0;
  logic edge_s = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic ber_flag, win_done;
  logic [CW-1:0] win_count;

  int n_tests = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ber_flag_monitor #(.WIN_BITS(WIN), .TH0(T0), .TH1(T1), .TH2(T2), .TH3(T3),
                     .CLR_WINDOWS(CLRW)) u_dut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .mid_sample(mid_s),
    .edge_sample(edge_s), .rate_sel(rate_sel), .ber_flag(ber_flag),
    .win_count(win_count), .win_done(win_done));

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int th_of(input int s);
    case (s)
      0: return T0;
      1: return T1;
      2: return T2;
      default: return T3;
    endcase
  endfunction

  task automatic do_reset(input int sel);
    @(negedge clk);
    rst = 1'b1; bit_valid = 1'b0; rate_sel = 2'(sel);
    @(posedge clk); @(posedge clk); #1;
    chk("R8 flag", ber_flag, 0);
    chk("R8 count", win_count, 0);
    chk("R8 done", win_done, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(input logic m, input logic e);
    @(negedge clk);
    bit_valid = 1'b1; mid_s = m; edge_s = e;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    bit_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic fill(input int n, input int nerr);
    for (int i = 0; i < n; i++) send(1'b0, (i >= n - nerr));
  endtask

  task automatic test_r1_detect();
    do_reset(0);
    send(0, 0); send(0, 1); send(1, 0); send(1, 1); send(1, 0); send(0, 1);
    fill(WIN - 7, 0);
    chk("R3 no pulse before end", win_done, 0);
    fill(1, 0);
    chk("R3 pulse at end", win_done, 1);
    chk("R1 error count", win_count, 2);
    send(0, 0);
    chk("R3 pulse single", win_done, 0);
    chk("R3 count held", win_count, 2);
  endtask

  task automatic test_r2_gap();
    do_reset(0);
    send(0, 1); send(0, 1);
    idle();
    send(0, 1); send(0, 1);
    fill(WIN - 4, 0);
    chk("R2 window end after gap", win_done, 1);
    chk("R2 unchecked bits", win_count, 2);
  endtask

  task automatic test_r5_thresholds();
    for (int s = 0; s < 4; s++) begin
      int t = th_of(s);
      do_reset(s);
      send(0, 0);
      fill(t - 1, t - 1);
      chk("R5 below threshold", ber_flag, 0);
      send(0, 1);
      chk("R5 at threshold", ber_flag, 1);
      fill(WIN - 1 - t, 0);
      chk("R5 window count", win_count, t);
    end
  endtask

  task automatic test_r4_saturate();
    do_reset(0);
    send(0, 0);
    fill(WIN - 1, WIN - 1);
    chk("R4 saturated count", win_count, T3);
    chk("R4 flag", ber_flag, 1);
  endtask

  task automatic test_r6_select();
    do_reset(3);
    send(0, 0);
    rate_sel = 2'd0;
    fill(6, 6);
    chk("R6 old threshold kept", ber_flag, 0);
    fill(WIN - 7, 0);
    chk("R6 count", win_count, 6);
    chk("R6 no flag at boundary", ber_flag, 0);
    fill(WIN, T0);
    chk("R6 new threshold used", ber_flag, 1);
  endtask

  task automatic test_r7_clear();
    do_reset(1);
    send(0, 0);
    fill(WIN - 1, T1);
    chk("R7 flag set", ber_flag, 1);
    for (int w = 0; w < CLRW - 1; w++) begin
      fill(WIN, 1);
      chk("R7 held during run", ber_flag, 1);
    end
    fill(WIN, T1 / 4);
    chk("R7 run restarted", ber_flag, 1);
    for (int w = 0; w < CLRW - 1; w++) begin
      fill(WIN, 1);
      chk("R7 held after restart", ber_flag, 1);
    end
    fill(WIN / 2, 0);
    chk("R9 no mid-window clear", ber_flag, 1);
    fill(WIN / 2, 1);
    chk("R7 cleared", ber_flag, 0);
    chk("R9 clear at boundary", win_done, 1);
    fill(WIN, 0);
    chk("R7 stays clear", ber_flag, 0);
    fill(WIN, T1);
    chk("R8 flag before reset", ber_flag, 1);
    do_reset(1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    test_r1_detect();
    test_r2_gap();
    test_r5_thresholds();
    test_r4_saturate();
    test_r6_select();
    test_r7_clear();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule